// File: doc/BRIEF.md
# Phase Alignment Search Controller

This block is a hardware sequencer that moves the phase of a derived clock until it lines up with a bus clock. It drives a wrapping phase code into an external phase shifter. After each new code it waits a settling interval and then inverts a load strobe so that the shifter accepts the code. It then reads a one-bit phase comparator. The aim is a falling transition of the comparator. The block does not take the first such transition it sees. Before it accepts one, it probes forward past the transition, probes back across it, rewinds behind it and locates it a second time.

Software or a power-up sequencer pulses `start_i` and waits for `done_o` or `fail_o`. On success the controller writes one last code, which is one below the code where the comparator last fell. It reports in `count_o` how many adjustments the search took. The search gives up after a bounded number of discarded attempts, or as soon as the adjustment count reaches its limit. After a failure the last code stays on the shifter.

Top module: `phase_align_seq`

## Requirements
- R1: During and after reset, `code_o` is 0, `load_o` is 0, `busy_o`, `done_o` and `fail_o` are low, and `count_o` is 0.
- R2: Every adjustment presents its code on `code_o` for at least SETTLE_CYC clock cycles and then inverts `load_o`. Between two consecutive inversions the code changes by 0, +1 or −1 modulo 2^CODE_W. Step arithmetic wraps, so 63+1 gives 0 and 0−1 gives 63. The comparator is sampled one cycle after the inversion.
- R3: In a search pass, a comparator reading of 1 makes the next code one higher and a reading of 0 makes it one lower. The pass ends when a reading is 0 and the reading before it was 1. A new attempt first rewrites the code it starts from.
- R4: After the first search pass, the controller steps forward. The first write repeats the transition code, and each later write adds 1. It stops after FWD_STEPS (5) steps or at the first reading of 1. It continues only if all FWD_STEPS steps were made and the last reading is 0. Otherwise it discards the attempt.
- R5: Next it steps backward by one code at a time while the comparator reads 0, for at most BACK_STEPS (3) steps. It discards the attempt if fewer than BACK_STEPS steps were made.
- R6: It then makes exactly REWIND_STEPS (5) more backward steps. It discards the attempt if the last reading is 0. Otherwise it runs the search of R3 again, taking the previous reading as 1.
- R7: When the second search finds its transition, the controller writes the last written code minus 1 (mod 2^CODE_W) and inverts `load_o` once more. It then pulses `done_o` for one cycle, and `count_o` holds the number of adjustments made. The final write is not counted as an adjustment.
- R8: An adjustment whose sample brings the count to MAX_ADJ ends the run with a one-cycle `fail_o`. This holds even if that same sample completes a transition. `count_o` then equals MAX_ADJ, and `code_o` keeps the last written value.
- R9: When an attempt is discarded for the MAX_ATT-th time, the run ends with `fail_o`.
- R10: `busy_o` is high from the cycle after the accepted start until the cycle in which `done_o` or `fail_o` pulses. A start pulse while busy has no effect on the run.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start_i | input | 1 | Start pulse, accepted only when idle |
| cmp_i | input | 1 | Phase comparator reading |
| code_o | output | CODE_W (6) | Phase code driven to the shifter |
| load_o | output | 1 | Load strobe, inverted once per written code |
| busy_o | output | 1 | Search in progress |
| done_o | output | 1 | One-cycle success pulse |
| fail_o | output | 1 | One-cycle failure pulse |
| count_o | output | clog2(MAX_ADJ+1) (16) | Adjustments made in the current or last run |

## Verification
Two events can fall on the same sample: the comparator completes a falling transition, and the adjustment counter reaches its limit. The bench provokes this with a comparator pattern that reads 1 everywhere except at a single code, placed 33 codes above the starting code. The first attempt is then discarded, and the second search sees its transition on exactly the hundredth adjustment. That run must end in failure with `count_o` at the limit and the code held, and not advance into the confirmation steps. A second overlap is a start pulse that arrives while a run is in progress. The bench judges it by comparing adjustment count, strobe inversions and final code against an arithmetic model of the search.

// File: rtl/pas_pkg.sv
package pas_pkg;

   typedef enum logic [1:0] {
      MS_IDLE,
      MS_SETTLE,
      MS_SAMPLE
   } micro_e;

   typedef enum logic [2:0] {
      ST_SEARCH,
      ST_FWD,
      ST_BACK,
      ST_REWIND,
      ST_RESEARCH,
      ST_COMMIT
   } stage_e;

endpackage

// File: rtl/pas_settle_timer.sv
module pas_settle_timer #(
   parameter int CYCLES = 5,
   localparam int TW = $clog2(CYCLES + 1)
) (
   input  logic clk,
   input  logic rst_n,
   input  logic kick,
   output logic settled
);

   logic [TW-1:0] cnt_q;

   generate
      if (CYCLES < 1) begin : g_bad_cycles
         $error("pas_settle_timer: CYCLES must be at least 1");
      end
   endgenerate

   always_ff @(posedge clk) begin
      if (!rst_n)
         cnt_q <= '0;
      else if (kick)
         cnt_q <= TW'(CYCLES);
      else if (cnt_q != '0)
         cnt_q <= cnt_q - TW'(1);
   end

   assign settled = (cnt_q == '0) && !kick;

   // a fresh code is never released in the cycle right after it was written
   p_settle_len_r2: assert property (@(posedge clk) disable iff (!rst_n)
      kick |=> !settled);

endmodule

// File: rtl/pas_bounded_counter.sv
module pas_bounded_counter #(
   parameter int LIMIT = 15,
   localparam int W = $clog2(LIMIT + 1)
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         clr,
   input  logic         inc,
   output logic [W-1:0] value
);

   generate
      if (LIMIT < 1) begin : g_bad_limit
         $error("pas_bounded_counter: LIMIT must be at least 1");
      end
   endgenerate

   always_ff @(posedge clk) begin
      if (!rst_n)
         value <= '0;
      else if (clr)
         value <= '0;
      else if (inc && value != W'(LIMIT))
         value <= value + W'(1);
   end

   p_cnt_bound_r8: assert property (@(posedge clk) disable iff (!rst_n)
      value <= W'(LIMIT));

endmodule

// File: rtl/phase_align_seq.sv
module phase_align_seq
   import pas_pkg::*;
#(
   parameter int CODE_W       = 6,
   parameter int SETTLE_CYC   = 5,
   parameter int MAX_ADJ      = 65535,
   parameter int MAX_ATT      = 10,
   parameter int FWD_STEPS    = 5,
   parameter int BACK_STEPS   = 3,
   parameter int REWIND_STEPS = 5,
   localparam int CNT_W       = $clog2(MAX_ADJ + 1)
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              start_i,
   input  logic              cmp_i,
   output logic [CODE_W-1:0] code_o,
   output logic              load_o,
   output logic              busy_o,
   output logic              done_o,
   output logic              fail_o,
   output logic [CNT_W-1:0]  count_o
);

   localparam int N_A   = (FWD_STEPS > BACK_STEPS) ? FWD_STEPS : BACK_STEPS;
   localparam int N_MAX = (N_A > REWIND_STEPS) ? N_A : REWIND_STEPS;
   localparam int N_W   = $clog2(N_MAX + 1);
   localparam int ATT_W = $clog2(MAX_ATT + 1);

   generate
      if (CODE_W < 2) begin : g_bad_code_w
         $error("phase_align_seq: CODE_W must be at least 2");
      end
      if (MAX_ADJ < 2) begin : g_bad_adj
         $error("phase_align_seq: MAX_ADJ must be at least 2");
      end
      if (FWD_STEPS < 1 || BACK_STEPS < 1 || REWIND_STEPS < 1) begin : g_bad_steps
         $error("phase_align_seq: confirmation step counts must be positive");
      end
   endgenerate

   micro_e            ms_q;
   stage_e            stage_q;
   logic [CODE_W-1:0] code_q;
   logic              load_q;
   logic              prev_q;
   logic              done_q;
   logic              fail_q;

   logic              kick, settled;
   logic              adj_clr, adj_inc, att_inc, n_clr, n_inc;
   logic [CNT_W-1:0]  adj_cnt;
   logic [ATT_W-1:0]  att_cnt;
   logic [N_W-1:0]    n_cnt;

   // ---------------- submodules ----------------
   pas_settle_timer #(.CYCLES(SETTLE_CYC)) u_timer (
      .clk(clk), .rst_n(rst_n), .kick(kick), .settled(settled));

   pas_bounded_counter #(.LIMIT(MAX_ADJ)) u_adj_cnt (
      .clk(clk), .rst_n(rst_n), .clr(adj_clr), .inc(adj_inc), .value(adj_cnt));

   pas_bounded_counter #(.LIMIT(MAX_ATT)) u_att_cnt (
      .clk(clk), .rst_n(rst_n), .clr(adj_clr), .inc(att_inc), .value(att_cnt));

   pas_bounded_counter #(.LIMIT(N_MAX)) u_step_cnt (
      .clk(clk), .rst_n(rst_n), .clr(n_clr), .inc(n_inc), .value(n_cnt));

   // ---------------- sample decision ----------------
   logic              s;
   logic [CNT_W:0]    adj_nx;
   logic [N_W:0]      n_nx;
   logic [ATT_W:0]    att_nx;
   logic              limit_hit, fall_seen, disc, att_out, give_up;
   logic              step_clr, upd_prev;
   logic [CODE_W-1:0] wr_code;
   stage_e            to_stage;

   assign s      = cmp_i;
   assign adj_nx = {1'b0, adj_cnt} + (CNT_W+1)'(1);
   assign n_nx   = {1'b0, n_cnt} + (N_W+1)'(1);
   assign att_nx = {1'b0, att_cnt} + (ATT_W+1)'(1);
   assign limit_hit = (adj_nx == (CNT_W+1)'(MAX_ADJ));
   assign fall_seen = (prev_q != s) && !s;

   always_comb begin
      wr_code  = code_q;
      to_stage = stage_q;
      step_clr = 1'b0;
      upd_prev = 1'b0;
      disc     = 1'b0;
      unique case (stage_q)
         ST_SEARCH, ST_RESEARCH: begin
            if (fall_seen && stage_q == ST_SEARCH) begin
               to_stage = ST_FWD;
               step_clr = 1'b1;
               wr_code  = code_q;                 // (code-1)+1
            end else if (fall_seen) begin
               to_stage = ST_COMMIT;
               wr_code  = code_q - CODE_W'(1);    // final minus-one correction
            end else begin
               upd_prev = 1'b1;
               wr_code  = s ? code_q + CODE_W'(1) : code_q - CODE_W'(1);
            end
         end
         ST_FWD: begin
            if (!s && n_nx < (N_W+1)'(FWD_STEPS))
               wr_code = code_q + CODE_W'(1);
            else if (n_nx == (N_W+1)'(FWD_STEPS) && !s) begin
               to_stage = ST_BACK;
               step_clr = 1'b1;
               wr_code  = code_q - CODE_W'(1);
            end else
               disc = 1'b1;
         end
         ST_BACK: begin
            if (!s && n_nx < (N_W+1)'(BACK_STEPS))
               wr_code = code_q - CODE_W'(1);
            else if (n_nx == (N_W+1)'(BACK_STEPS)) begin
               to_stage = ST_REWIND;
               step_clr = 1'b1;
               wr_code  = code_q - CODE_W'(1);
            end else
               disc = 1'b1;
         end
         ST_REWIND: begin
            if (n_nx < (N_W+1)'(REWIND_STEPS))
               wr_code = code_q - CODE_W'(1);
            else if (s) begin
               to_stage = ST_RESEARCH;
               upd_prev = 1'b1;
               wr_code  = code_q;
            end else
               disc = 1'b1;
         end
         default: ;
      endcase
      if (disc) begin
         to_stage = ST_SEARCH;
         step_clr = 1'b1;
         upd_prev = 1'b1;
         wr_code  = code_q;
      end
   end

   assign att_out = disc && (att_nx >= (ATT_W+1)'(MAX_ATT));
   assign give_up = limit_hit || att_out;

   // ---------------- counter and timer control ----------------
   assign adj_clr = (ms_q == MS_IDLE) && start_i;
   assign kick    = adj_clr || ((ms_q == MS_SAMPLE) && !give_up);
   assign adj_inc = (ms_q == MS_SAMPLE);
   assign att_inc = (ms_q == MS_SAMPLE) && disc && !give_up;
   assign n_clr   = adj_clr || ((ms_q == MS_SAMPLE) && step_clr);
   assign n_inc   = (ms_q == MS_SAMPLE) && !step_clr;

   // ---------------- sequencer ----------------
   always_ff @(posedge clk) begin
      if (!rst_n) begin
         ms_q    <= MS_IDLE;
         stage_q <= ST_SEARCH;
         code_q  <= '0;
         load_q  <= 1'b0;
         prev_q  <= 1'b0;
         done_q  <= 1'b0;
         fail_q  <= 1'b0;
      end else begin
         done_q <= 1'b0;
         fail_q <= 1'b0;
         unique case (ms_q)
            MS_IDLE: begin
               if (start_i) begin
                  ms_q    <= MS_SETTLE;
                  stage_q <= ST_SEARCH;
                  prev_q  <= cmp_i;
               end
            end
            MS_SETTLE: begin
               if (settled) begin
                  load_q <= ~load_q;
                  if (stage_q == ST_COMMIT) begin
                     ms_q   <= MS_IDLE;
                     done_q <= 1'b1;
                  end else
                     ms_q <= MS_SAMPLE;
               end
            end
            MS_SAMPLE: begin
               if (give_up) begin
                  ms_q   <= MS_IDLE;
                  fail_q <= 1'b1;
               end else begin
                  code_q  <= wr_code;
                  stage_q <= to_stage;
                  if (upd_prev)
                     prev_q <= s;
                  ms_q <= MS_SETTLE;
               end
            end
            default: ms_q <= MS_IDLE;
         endcase
      end
   end

   assign code_o  = code_q;
   assign load_o  = load_q;
   assign busy_o  = (ms_q != MS_IDLE);
   assign done_o  = done_q;
   assign fail_o  = fail_q;
   assign count_o = adj_cnt;

   // ---------------- assertions ----------------
   p_unit_step_r2: assert property (@(posedge clk) disable iff (!rst_n)
      (code_q != $past(code_q)) |->
         ((code_q - $past(code_q)) == CODE_W'(1) ||
          (code_q - $past(code_q)) == {CODE_W{1'b1}}));

   p_load_after_settle_r2: assert property (@(posedge clk) disable iff (!rst_n)
      (load_q != $past(load_q)) |-> ($past(ms_q) == MS_SETTLE && code_q == $past(code_q)));

   p_done_with_strobe_r7: assert property (@(posedge clk) disable iff (!rst_n)
      done_q |-> (load_q != $past(load_q) && $past(stage_q) == ST_COMMIT));

   p_fail_holds_code_r8: assert property (@(posedge clk) disable iff (!rst_n)
      fail_q |-> (code_q == $past(code_q) && $past(ms_q) == MS_SAMPLE));

   p_attempt_cap_r9: assert property (@(posedge clk) disable iff (!rst_n)
      att_cnt < ATT_W'(MAX_ATT));

   p_end_is_idle_r10: assert property (@(posedge clk) disable iff (!rst_n)
      (done_q || fail_q) |-> (ms_q == MS_IDLE && !(done_q && fail_q)));

   p_start_ignored_r10: assert property (@(posedge clk) disable iff (!rst_n)
      (ms_q == MS_SETTLE && !settled && start_i) |=> (ms_q == MS_SETTLE && $stable(code_q)));

endmodule

// File: tb/phase_align_seq_tb_top.sv
module phase_align_seq_tb_top;

   localparam int CW   = 6;
   localparam int SC   = 2;
   localparam int MA   = 100;
   localparam int MT   = 10;
   localparam int CNTW = $clog2(MA + 1);

   logic            clk = 1'b0;
   logic            rst_n = 1'b0;
   logic            start = 1'b0;
   logic [63:0]     pat = '1;
   logic [CW-1:0]   lat = '0;
   logic            last_ld = 1'b0;
   logic            cmp;
   logic [CW-1:0]   code;
   logic            load, busy, done, fail;
   logic [CNTW-1:0] count;

   int checks = 0;
   int fails = 0;
   int toggles = 0;
   int hold = 0;
   int cyc = 0;
   logic [CW-1:0] mon_code = '0;

   always #2 clk = ~clk;   // 250 MHz

   assign cmp = pat[lat];

   phase_align_seq #(
      .CODE_W(CW), .SETTLE_CYC(SC), .MAX_ADJ(MA), .MAX_ATT(MT)
   ) dut_i (
      .clk(clk), .rst_n(rst_n), .start_i(start), .cmp_i(cmp),
      .code_o(code), .load_o(load), .busy_o(busy), .done_o(done),
      .fail_o(fail), .count_o(count));

   task automatic chk(input bit ok, input string req, input string what,
                      input int act, input int exp);
      checks++;
      if (!ok) begin
         fails++;
         $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
      end
   endtask

   // phase shifter and comparator model, plus strobe monitor (R2)
   always @(negedge clk) begin
      if (!rst_n) begin
         lat = '0;
         last_ld = 1'b0;
         hold = 0;
         mon_code = '0;
      end else begin
         if (code != mon_code) begin
            mon_code = code;
            hold = 0;
         end else
            hold++;
         if (load != last_ld) begin
            logic [CW-1:0] delta;
            last_ld = load;
            toggles++;
            delta = code - lat;
            chk(hold >= SC, "R2", "settle cycles before strobe", hold, SC);
            chk(delta == 0 || delta == 1 || delta == 63, "R2", "code delta mod 64",
                int'(delta), 1);
            lat = code;
         end
      end
   end

   always @(posedge clk) begin
      cyc++;
      if (cyc == 190000) begin
         fails++;
         $display("FAIL R10 watchdog expired actual=%0d expected=%0d", cyc, 0);
         $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
         $finish;
      end
   end

   // arithmetic model of the search
   task automatic model(input logic [CW-1:0] st, input logic [63:0] pt,
                        output bit ok, output logic [CW-1:0] fc, output int cnt);
      logic [CW-1:0] c, nx;
      bit p, s, stop, found;
      int adj, n;
      c = st; nx = st; adj = 0; p = pt[st]; s = p; ok = 0; stop = 0;
      for (int a = 0; a < MT && !stop; a++) begin
         nx = c; found = 0;
         while (!stop && !found) begin
            c = nx; adj++; s = pt[c];
            if (adj == MA) stop = 1;
            else begin
               if (p != s && !s) found = 1;
               p = s;
               nx = s ? c + 1 : c - 1;
            end
         end
         if (stop) break;
         n = 0;
         while (!stop && n < 5 && !s) begin
            nx = nx + 1; c = nx; adj++; s = pt[c]; n++;
            if (adj == MA) stop = 1;
         end
         if (stop) break;
         if (n != 5) begin p = s; continue; end
         n = 0;
         while (!stop && n < 3 && !s) begin
            nx = nx - 1; c = nx; adj++; s = pt[c]; n++;
            if (adj == MA) stop = 1;
         end
         if (stop) break;
         if (n != 3) begin p = s; continue; end
         n = 0;
         while (!stop && n < 5) begin
            nx = nx - 1; c = nx; adj++; s = pt[c]; n++;
            if (adj == MA) stop = 1;
         end
         if (stop) break;
         if (!s) begin p = s; continue; end
         p = s; nx = c; found = 0;
         while (!stop && !found) begin
            c = nx; adj++; s = pt[c];
            if (adj == MA) stop = 1;
            else begin
               if (p != s && !s) found = 1;
               p = s;
               nx = s ? c + 1 : c - 1;
            end
         end
         if (stop) break;
         c = c - 1; ok = 1; stop = 1;
      end
      fc = c; cnt = adj;
   endtask

   task automatic run_case(input logic [63:0] pt, input string tag);
      bit eok, got;
      logic [CW-1:0] ec;
      int ecnt, t0;
      pat = pt;
      model(code, pt, eok, ec, ecnt);
      @(negedge clk);
      t0 = toggles;
      start = 1'b1;
      @(negedge clk);
      start = 1'b0;
      chk(busy == 1'b1, "R10", "busy after start", busy, 1);
      got = 0;
      for (int i = 0; i < 20000 && !got; i++) begin
         @(negedge clk);
         if (done || fail) got = 1;
         if (i == 4) start = 1'b1;        // ignored while busy (R10)
         if (i == 5) start = 1'b0;
      end
      start = 1'b0;
      chk(got, "R10", "run finished", got, 1);
      chk(done == eok && fail == !eok && busy == 1'b0, tag, "done/fail outcome",
          int'(done), int'(eok));
      chk(int'(count) == ecnt, tag, "adjustment count", int'(count), ecnt);
      @(negedge clk);
      chk(code == ec, tag, "final code", int'(code), int'(ec));
      chk(toggles - t0 == ecnt + int'(eok), "R7 R10", "strobe inversions",
          toggles - t0, ecnt + int'(eok));
      if (!eok) begin
         repeat (3) @(negedge clk);
         chk(code == ec, "R8", "code held after fail", int'(code), int'(ec));
      end
   endtask

   function automatic logic [63:0] window(input int e, input int w);
      logic [63:0] r;
      for (int i = 0; i < 64; i++) r[i] = (((i - e) & 63) < w);
      return r;
   endfunction

   initial begin
      logic [63:0] pp;
      repeat (4) @(negedge clk);
      chk(code == 0 && load == 0, "R1", "code/strobe in reset", int'(code), 0);
      chk(!busy && !done && !fail && count == 0, "R1", "status in reset", int'(busy), 0);
      rst_n = 1'b1;
      @(negedge clk);
      chk(code == 0 && load == 0 && !busy && count == 0, "R1", "state after reset",
          int'(code), 0);

      for (int e = 0; e < 64; e++) run_case(window(e, 32), "R3 R4 R5 R6 R7");
      for (int e = 0; e < 64; e += 4) run_case(window(e, 12), "R3 R6 R7");
      for (int e = 0; e < 64; e += 8) begin
         for (int g = 33; g <= 36; g++) begin
            pp = window(e, 32);
            pp[(e + g) & 63] = 1'b1;
            run_case(pp, "R4 R5 R6");
         end
      end
      for (int z = 0; z < 64; z += 3) begin
         pp = '1;
         pp[z] = 1'b0;
         run_case(pp, "R4 R8 R9");
      end
      for (int i = 0; i < 64; i++) pp[i] = ((i % 5) < 3);
      run_case(pp, "R9");
      run_case(64'd0, "R3 R8");
      run_case('1, "R3 R8");
      // transition completes on the very adjustment that reaches the limit
      pp = '1;
      pp[(int'(code) + 33) & 63] = 1'b0;
      run_case(pp, "R8");

      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
   end

endmodule